// File: doc/BRIEF.md
# SDRAM Bank Burst Engine with Early Termination

This block models the memory side of one single-data-rate synchronous DRAM bank data path at cycle level. Each clock edge it samples a command (Read, Write, Precharge, Burst Stop or no-op) together with a column address and a per-cycle mask bit. It runs the burst that the command starts and steps a column counter that wraps inside the burst-sized column group. Write beats go into a small internal cell array. Read beats are fetched from that array and pass through a CAS-latency pipeline before they reach an output bus. The bus is modelled as a data output plus a drive-enable.

A burst can end early. A Precharge or Burst Stop cancels the rest of a burst from the edge where it is sampled. For a read, beats that are already in the latency pipeline still come out, so data stops CAS-latency-minus-one cycles after the command. For a write, the cut takes effect at once. A Read or Write that arrives during a burst replaces it in the same edge. The mask bit acts at once on write acceptance and two cycles later on read output drive.

Top module: `sdr_burst_engine`

## Requirements
- R1: While rst_n is low, and in the cycles after release until a Read command's data is due, dq_oe is low.
- R2: The cmd encoding is 0 no-op, 1 Read, 2 Write, 3 Precharge, 4 Burst Stop. Beat i of a Read sampled at edge n is registered onto dq_out/dq_oe at edge n+CL-1+i, so the controller samples it at edge n+CL+i. CL is 2 when cfg_cl3 is 0 and 3 when it is 1.
- R3: cfg_bl values 0, 1, 2, 3 give bursts of 1, 2, 4, 8 beats. The column of beat i keeps the base column's upper bits and replaces its low log2(BL) bits with (base+i) mod BL.
- R4: A write beat is stored at the edge where it is presented; the Write command's own edge carries beat 0. If dqm is high at that edge, the word is left unchanged.
- R5: A Precharge or Burst Stop during a read burst launches no beat at its own edge or later. The last data shown is the beat launched one edge earlier, visible CL-1 cycles after the command.
- R6: A Precharge or Burst Stop during a write burst stores nothing presented at its own edge or at any later edge of that burst.
- R7: A Read during a write burst keeps the beats stored before it, discards the remaining write beats, and launches its own beat 0 at the same edge.
- R8: A Write during a read burst stops further read launches. Read beats launched before it are still driven at their latency unless masked, and write beats are stored from the Write edge on.
- R9: dqm high at edge e forces dq_oe low in the cycle after edge e+1, whatever read data is due then.
- R10: A Read or Write is accepted in any cycle, including mid-burst. It abandons the running burst and starts a new one with beat 0 at its own column in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code sampled each edge |
| col | input | COL_W | Column address, used with Read and Write |
| dqm | input | 1 | Data mask: blocks a write at once, blanks read output two cycles later |
| dq_in | input | DW | Write data from the controller |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| cfg_bl | input | 2 | Burst length code |
| dq_out | output | DW | Read data, zero when not driven |
| dq_oe | output | 1 | Output drive enable; low means the bus is high impedance |

## Verification
Full-length bursts at aligned and unaligned columns, across every burst length, separate correct column wrap from plain counting. Reads that follow masked writes show whether the mask is applied with zero latency. Each interrupt kind (Precharge, Burst Stop, Read over Write, Write over Read, Read over Read) is placed mid-burst at both CAS latencies. This tells a cut at the command edge apart from one a cycle early or late, for both directions. Mask bits scattered through a read burst confirm the two-cycle output masking, and full readbacks of the array expose any stray or missing write.

// File: rtl/sdr_be_pkg.sv
package sdr_be_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_READ      = 3'd1,
        CMD_WRITE     = 3'd2,
        CMD_PRECHARGE = 3'd3,
        CMD_BSTOP     = 3'd4
    } cmd_e;

    // Deepest CAS latency supported by the read pipeline.
    localparam int CL_MAX = 3;
    // Longest burst is 8 beats: 3 bits of beat index.
    localparam int BEAT_W = 3;

    // Burst length code to group mask (BL-1).
    function automatic logic [BEAT_W-1:0] grp_mask(input logic [1:0] bl_code);
        case (bl_code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sdr_be_seq.sv
module sdr_be_seq
    import sdr_be_pkg::*;
#(
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       cfg_bl,
    output logic             beat_vld,
    output logic             beat_rd,
    output logic [COL_W-1:0] beat_col
);

    typedef struct packed {
        logic              act;
        logic              rd;
        logic [COL_W-1:0]  base;
        logic [BEAT_W-1:0] cnt;
        logic [BEAT_W-1:0] gmask;
    } seq_t;

    seq_t st_d, st_q;

    logic [COL_W-1:0]  sel_base;
    logic [BEAT_W-1:0] sel_off;
    logic [BEAT_W-1:0] sel_mask;
    logic [COL_W-1:0]  wide_mask;
    logic              is_rw;
    logic              is_stop;

    assign is_rw   = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign is_stop = (cmd == CMD_PRECHARGE) || (cmd == CMD_BSTOP);

    always_comb begin
        st_d     = st_q;
        beat_vld = 1'b0;
        beat_rd  = st_q.rd;
        sel_base = st_q.base;
        sel_off  = st_q.cnt;
        sel_mask = st_q.gmask;
        if (is_rw) begin
            st_d.rd    = (cmd == CMD_READ);
            st_d.base  = col;
            st_d.gmask = grp_mask(cfg_bl);
            st_d.cnt   = BEAT_W'(1);
            st_d.act   = (grp_mask(cfg_bl) != '0);
            beat_vld   = 1'b1;
            beat_rd    = (cmd == CMD_READ);
            sel_base   = col;
            sel_off    = '0;
            sel_mask   = grp_mask(cfg_bl);
        end else if (is_stop) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            beat_vld = 1'b1;
            st_d.cnt = st_q.cnt + BEAT_W'(1);
            st_d.act = (st_q.cnt != st_q.gmask);
        end
    end

    // Wrap inside the burst-aligned column group.
    assign wide_mask = COL_W'(sel_mask);
    assign beat_col  = (sel_base & ~wide_mask) | ((sel_base + COL_W'(sel_off)) & wide_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5/R6: a stop command never yields a beat in its own cycle
    a_r5_stop_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |-> !beat_vld);

    // R10: a Read or Write starts beat 0 at its own column right away
    a_r10_cmd_starts_beat: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> (beat_vld && beat_col == col && beat_rd == (cmd == CMD_READ)));

    // R3: a continuation beat always follows a beat of the same direction
    a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !is_rw) |-> ($past(beat_vld) && beat_rd == $past(beat_rd)));

    // R3: burst length 1 leaves nothing for the next cycle
    a_r3_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && cfg_bl == 2'd0) |=> (is_rw || !beat_vld));

endmodule

// File: rtl/sdr_be_cells.sv
module sdr_be_cells #(
    parameter int DW    = 16,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [COL_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [COL_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << COL_W;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

    // R4: an accepted write is visible at its column one cycle later
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sdr_be_rdpipe.sv
module sdr_be_rdpipe
    import sdr_be_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cl3,
    input  logic          launch_vld,
    input  logic [DW-1:0] launch_data,
    input  logic          dqm,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    localparam int TAP_W = $clog2(CL_MAX);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } stage_t;

    typedef struct packed {
        stage_t [CL_MAX-1:0] stg;
        logic                dqm1;
        logic                dqm2;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic [TAP_W-1:0] tap;

    always_comb begin
        pp_d            = pp_q;
        pp_d.stg[0].vld  = launch_vld;
        pp_d.stg[0].data = launch_data;
        for (int i = 1; i < CL_MAX; i++) begin
            pp_d.stg[i] = pp_q.stg[i-1];
        end
        pp_d.dqm1 = dqm;
        pp_d.dqm2 = pp_q.dqm1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    // Stage k holds a beat launched k+1 edges ago; CL=2 taps stage 1.
    assign tap    = cfg_cl3 ? TAP_W'(2) : TAP_W'(1);
    assign dq_oe  = pp_q.stg[tap].vld & ~pp_q.dqm2;
    assign dq_out = dq_oe ? pp_q.stg[tap].data : '0;

    // R2: unmasked read beat is driven CL cycles after launch
    a_r2_cl2_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cl3 && $past(launch_vld, 2) && !$past(dqm, 2)) |-> (dq_oe && dq_out == $past(launch_data, 2)));
    a_r2_cl3_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl3 && $past(launch_vld, 3) && !$past(dqm, 2)) |-> (dq_oe && dq_out == $past(launch_data, 3)));

    // R5: without a launch at the right distance the bus stays released
    a_r5_cl2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cl3 && !$past(launch_vld, 2)) |-> !dq_oe);
    a_r5_cl3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl3 && !$past(launch_vld, 3)) |-> !dq_oe);

    // R9: mask two cycles back blanks the output
    a_r9_mask_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dqm, 2) |-> !dq_oe);

endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_be_pkg::*;
#(
    parameter int DW    = 16,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [COL_W-1:0] col,
    input  logic             dqm,
    input  logic [DW-1:0]    dq_in,
    input  logic             cfg_cl3,
    input  logic [1:0]       cfg_bl,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    logic             beat_vld;
    logic             beat_rd;
    logic [COL_W-1:0] beat_col;
    logic             wr_en;
    logic             rd_launch;
    logic [DW-1:0]    cell_rdata;

    sdr_be_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .col      (col),
        .cfg_bl   (cfg_bl),
        .beat_vld (beat_vld),
        .beat_rd  (beat_rd),
        .beat_col (beat_col)
    );

    // Write mask has no latency: the beat's own dqm gates it.
    assign wr_en     = beat_vld & ~beat_rd & ~dqm;
    assign rd_launch = beat_vld & beat_rd;

    sdr_be_cells #(.DW(DW), .COL_W(COL_W)) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (beat_col),
        .wdata (dq_in),
        .raddr (beat_col),
        .rdata (cell_rdata)
    );

    sdr_be_rdpipe #(.DW(DW)) u_rdpipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cl3     (cfg_cl3),
        .launch_vld  (rd_launch),
        .launch_data (cell_rdata),
        .dqm         (dqm),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

    // R6: Precharge or Burst Stop never stores the data of its own cycle
    a_r6_stop_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRECHARGE || cmd == CMD_BSTOP) |-> !wr_en);

    // R4: a masked beat is never written
    a_r4_mask_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        dqm |-> !wr_en);

    // R7: a Read edge stores no write data
    a_r7_read_cuts_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) |-> (!wr_en && rd_launch));

endmodule

// File: tb/sim_sdr_burst_engine.sv
`timescale 1ns/1ps
module sim_sdr_burst_engine;
    import sdr_be_pkg::*;

    localparam int DW    = 16;
    localparam int COL_W = 5;
    localparam int NCOL  = 1 << COL_W;
    localparam int HIST  = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [COL_W-1:0] col = '0;
    logic             dqm = 1'b0;
    logic [DW-1:0]    dq_in = '0;
    logic             cfg_cl3 = 1'b0;
    logic [1:0]       cfg_bl = 2'd3;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    sdr_burst_engine #(.DW(DW), .COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .col(col), .dqm(dqm), .dq_in(dq_in),
        .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int            cyc;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] ref_mem [NCOL];
    bit            mask_h [HIST];
    int            cyc = 0;
    int            nvec = 0;
    int            nbad = 0;
    bit            mon_en = 1'b0;
    string         tag = "R1";
    int            cl_sel = 2;
    int            bl_sel = 3;
    int            cl = 2;
    bit            m_act = 1'b0;
    bit            m_rd = 1'b0;
    int            m_base = 0;
    int            m_cnt = 0;
    int            m_len = 1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return DW'(seed * 16'h0907 + i * 16'h0131 + 16'h1000);
    endfunction

    // Driver: applies one edge of stimulus and records expectations.
    task automatic step(input logic [2:0] c, input int colv, input logic m, input logic [DW-1:0] d);
        int e;
        int a;
        int idx;
        bit beat;
        @(negedge clk);
        cmd = c; col = COL_W'(colv); dqm = m; dq_in = d;
        cfg_bl = 2'(bl_sel); cfg_cl3 = (cl_sel == 3);
        cl = cl_sel;
        e = cyc + 1;
        mask_h[e + 1] = m;
        beat = 1'b0;
        idx = 0;
        if (c == CMD_READ || c == CMD_WRITE) begin
            m_len = 1 << bl_sel; m_act = (m_len > 1); m_rd = (c == CMD_READ);
            m_base = colv; m_cnt = 1; beat = 1'b1; idx = 0;
        end else if (c == CMD_PRECHARGE || c == CMD_BSTOP) begin
            m_act = 1'b0;
        end else if (m_act) begin
            beat = 1'b1; idx = m_cnt; m_cnt++;
            if (m_cnt == m_len) m_act = 1'b0;
        end
        if (beat) begin
            a = (m_base & ~(m_len - 1)) | ((m_base + idx) & (m_len - 1));
            if (m_rd) q.push_back('{e + cl - 1, ref_mem[a], tag});
            else if (!m) ref_mem[a] = d;
        end
        @(posedge clk);
    endtask

    task automatic run(input logic [2:0] c, input int colv, input int n, input int seed, input logic [7:0] mb);
        step(c, colv, mb[0], pat(seed, 0));
        for (int i = 1; i < n; i++) step(CMD_NOP, 0, mb[i], pat(seed, i));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(CMD_NOP, 0, 1'b0, '0);
    endtask

    // Monitor: compares the bus every cycle against the scoreboard.
    always @(negedge clk) begin
        bit            eo;
        logic [DW-1:0] ed;
        string         t;
        if (mon_en) begin
            eo = 1'b0; ed = '0; t = tag;
            if (q.size() > 0 && q[0].cyc == cyc) begin
                eo = !mask_h[cyc]; ed = q[0].d; t = q[0].tag;
                void'(q.pop_front());
            end
            nvec++;
            if (dq_oe !== eo || (eo && dq_out !== ed)) begin
                nbad++;
                $display("FAIL %s cycle %0d: oe=%b data=%h expected oe=%b data=%h",
                         t, cyc, dq_oe, dq_out, eo, ed);
            end
        end
    end

    task automatic phase(input int c);
        cl_sel = c; idle(4);
        tag = "R4"; bl_sel = 3;
        for (int k = 0; k < 4; k++) run(CMD_WRITE, k * 8, 8, c * 16 + k, 8'h00);
        idle(2);
        tag = "R2"; run(CMD_READ, 0, 8, 0, 8'h00); idle(4);
        tag = "R3"; run(CMD_READ, 13, 8, 0, 8'h00); idle(4);
        bl_sel = 2; run(CMD_READ, 6, 4, 0, 8'h00); idle(4);
        bl_sel = 0; run(CMD_READ, 21, 1, 0, 8'h00); idle(4);
        bl_sel = 1; run(CMD_READ, 31, 2, 0, 8'h00); idle(4);
        tag = "R4"; bl_sel = 2; run(CMD_WRITE, 2, 4, c * 16 + 5, 8'b0000_0010); idle(2);
        run(CMD_READ, 0, 4, 0, 8'h00); idle(4);
        tag = "R5"; bl_sel = 3; run(CMD_READ, 16, 3, 0, 8'h00);
        step(CMD_PRECHARGE, 0, 1'b0, '0); idle(5);
        run(CMD_READ, 24, 5, 0, 8'h00); step(CMD_BSTOP, 0, 1'b0, '0); idle(5);
        tag = "R6"; run(CMD_WRITE, 8, 3, c * 16 + 6, 8'h00);
        step(CMD_BSTOP, 0, 1'b0, 16'hdead); run(CMD_NOP, 0, 3, c * 16 + 7, 8'h00);
        run(CMD_WRITE, 16, 4, c * 16 + 8, 8'h00);
        step(CMD_PRECHARGE, 0, 1'b1, 16'hbeef); idle(2);
        run(CMD_READ, 8, 8, 0, 8'h00); run(CMD_READ, 16, 8, 0, 8'h00); idle(4);
        tag = "R7"; run(CMD_WRITE, 0, 2, c * 16 + 9, 8'h00);
        run(CMD_READ, 24, 8, 0, 8'h00); idle(4);
        run(CMD_READ, 0, 8, 0, 8'h00); idle(4);
        tag = "R8"; run(CMD_READ, 8, 3, 0, 8'b0000_0100);
        run(CMD_WRITE, 4, 8, c * 16 + 10, 8'b0000_0001); idle(4);
        run(CMD_READ, 0, 8, 0, 8'h00); idle(4);
        run(CMD_READ, 16, 3, 0, 8'h00); run(CMD_WRITE, 20, 8, c * 16 + 11, 8'h00); idle(4);
        run(CMD_READ, 16, 8, 0, 8'h00); idle(4);
        tag = "R9"; run(CMD_READ, 24, 8, 0, 8'b0100_1001); idle(4);
        tag = "R10"; run(CMD_READ, 0, 3, 0, 8'h00); run(CMD_READ, 13, 8, 0, 8'h00); idle(4);
        bl_sel = 2; run(CMD_READ, 4, 2, 0, 8'h00); run(CMD_READ, 9, 4, 0, 8'h00); idle(4);
        tag = "R3"; bl_sel = 3;
        for (int k = 0; k < 4; k++) run(CMD_READ, k * 8, 8, 0, 8'h00);
        idle(6);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        nvec++;   // R1: bus released in reset
        if (dq_oe !== 1'b0) begin
            nbad++;
            $display("FAIL R1 reset: oe=%b expected oe=0", dq_oe);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        tag = "R1"; idle(3);
        phase(2);
        phase(3);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule